// File: doc/BRIEF.md
# Age-Priority DRAM Command Multiplexer

This block picks, in every clock cycle, at most one DRAM command from a set of candidate sources: one per bank machine, one refresh manager and one power-down manager. Each source offers a command with a valid flag, a 3-bit command kind and the wrapping sequence number of the transaction that owns it. Upstream logic raises a valid flag only when its command meets all timing rules in that cycle. This block decides only which ready command goes out. The chosen command appears on the output in the same cycle. A one-hot grant goes back to the source whose command was taken.

Priority is set first by source class and then by age. A refresh request always wins. A power-down request is taken only when nothing else can go. Among bank commands, the oldest transaction wins, and ties go to the lower bank index.

A mode input turns on strict ordering. In that mode, read and write commands must leave in the order their requests arrived. A read or write whose sequence number is not the next one expected is held back, even when it is the oldest. Strict mode assumes a first-in-first-out scheduler upstream that gives every request exactly one read or write, with contiguous sequence numbers. Activate and precharge commands are never held back by this rule.

Top module: `cmdmux_top`

## Requirements
- R1: When no source is valid, `grant` is all zero and `cmd_valid` is 0.
- R2: At most one `grant` bit is set. When `cmd_valid` is 1, `cmd_src`, `cmd_kind` and `cmd_seq` are the index, kind and sequence number of the granted source. Source indices 0 to NUM_BANKS-1 are the banks, index NUM_BANKS is refresh and index NUM_BANKS+1 is power-down.
- R3: A valid refresh source is always granted, whatever the other sources offer.
- R4: The power-down source is granted only when refresh is not valid and no bank source is eligible.
- R5: Among eligible bank sources, the one with the oldest sequence number is granted. Sequence number a is older than b when (a - b) modulo 2^SEQ_W has its top bit set.
- R6: When eligible bank sources carry equal sequence numbers, the lowest index wins.
- R7: With `strict_mode` = 1, a bank read (kind 2) or write (kind 3) is eligible only when its sequence number equals the expected next number. Otherwise it is held back, even when it is the oldest.
- R8: In strict mode, bank activate (kind 0) and precharge (kind 1) commands stay eligible whatever their sequence number.
- R9: After each granted bank read or write, in either mode, the expected next number becomes that command's sequence number plus one, modulo 2^SEQ_W.
- R10: Synchronous active-low reset sets the expected next number to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strict_mode | input | 1 | 0 = oldest-first, 1 = strict read/write order |
| src_valid | input | NUM_BANKS+2 | Per-source command ready |
| src_kind | input | 3*(NUM_BANKS+2) | Per-source command kind, 3 bits each |
| src_seq | input | SEQ_W*(NUM_BANKS+2) | Per-source transaction sequence number |
| grant | output | NUM_BANKS+2 | One-hot grant back to the sources |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_kind | output | 3 | Kind of the issued command |
| cmd_seq | output | SEQ_W | Sequence number of the issued command |
| cmd_src | output | clog2(NUM_BANKS+2) | Index of the granted source |

## Verification
A vector table in oldest-first mode covers these cases:
- no requesters;
- a single requester;
- several bank requesters at spread-out ages, which separates a true age compare from a fixed index priority;
- sequence numbers across the wrap point, which separates modular compare from plain magnitude compare;
- equal ages, which checks the tie rule;
- every mix of refresh and power-down with bank commands, which tests the class ordering.

Directed strict-mode sequences then set an older out-of-order read against a younger in-order one, and an out-of-order read against activate and precharge commands. These steps show whether the expected number advances only on granted reads and writes, and whether reset returns it to zero.

// File: rtl/cmdmux_pkg.sv
// Package: command kinds and shared constants of the command multiplexer.
// Assumes every source encodes its command kind in 3 bits.
package cmdmux_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        KIND_ACT = 3'd0,
        KIND_PRE = 3'd1,
        KIND_RD  = 3'd2,
        KIND_WR  = 3'd3,
        KIND_REF = 3'd4,
        KIND_PDE = 3'd5,
        KIND_PDX = 3'd6,
        KIND_NOP = 3'd7
    } cmd_kind_t;

    // True for data-moving commands that strict ordering governs.
    function automatic logic is_data_cmd(input logic [KIND_W-1:0] k);
        return (k == KIND_RD) || (k == KIND_WR);
    endfunction

endpackage

// File: rtl/cmdmux_bank_filter.sv
// Bank filter: marks each bank source as eligible this cycle.
// Assumes timing legality is already folded into src_valid. It adds only
// the strict-order gate on reads and writes.
module cmdmux_bank_filter
    import cmdmux_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int SEQ_W     = 8
) (
    input  logic                        strict_mode,
    input  logic [NUM_BANKS-1:0]        bank_valid,
    input  logic [NUM_BANKS*KIND_W-1:0] bank_kind,
    input  logic [NUM_BANKS*SEQ_W-1:0]  bank_seq,
    input  logic [SEQ_W-1:0]            expect_seq,
    output logic [NUM_BANKS-1:0]        bank_elig
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             data_cmd;
        logic             in_order;
        logic [SEQ_W-1:0] seq_b;

        // Decode one bank's offer and apply the strict-order gate.
        always_comb begin
            seq_b        = bank_seq[b*SEQ_W +: SEQ_W];
            data_cmd     = is_data_cmd(bank_kind[b*KIND_W +: KIND_W]);
            in_order     = (seq_b == expect_seq);
            bank_elig[b] = bank_valid[b] && (!strict_mode || !data_cmd || in_order);
        end
    end

endmodule

// File: rtl/cmdmux_age_pick.sv
// Age picker: finds the oldest marked entry using modular sequence compare.
// Ties keep the lower index. Assumes all live sequence numbers are within
// half the number space of each other.
module cmdmux_age_pick #(
    parameter int NUM   = 4,
    parameter int SEQ_W = 8,
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [NUM-1:0]       cand,
    input  logic [NUM*SEQ_W-1:0] cand_seq,
    output logic                 found,
    output logic [IDX_W-1:0]     pick_idx
);

    logic [SEQ_W-1:0] best_seq;
    logic [SEQ_W-1:0] diff;

    // Linear scan: replace the holder only on a strictly older entry.
    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        best_seq = '0;
        diff     = '0;
        for (int i = 0; i < NUM; i++) begin
            diff = cand_seq[i*SEQ_W +: SEQ_W] - best_seq;
            if (cand[i] && (!found || diff[SEQ_W-1])) begin
                found    = 1'b1;
                pick_idx = IDX_W'(i);
                best_seq = cand_seq[i*SEQ_W +: SEQ_W];
            end
        end
    end

endmodule

// File: rtl/cmdmux_order_track.sv
// Order tracker: holds the sequence number the next read/write must carry.
// Assumes each transaction owns exactly one read or write command.
module cmdmux_order_track #(
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_issued,
    input  logic [SEQ_W-1:0] issued_seq,
    output logic [SEQ_W-1:0] expect_seq
);

    // Advance past each issued data command; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expect_seq <= '0;
        end else if (data_issued) begin
            expect_seq <= issued_seq + SEQ_W'(1);
        end
    end

endmodule

// File: rtl/cmdmux_top.sv
// Command multiplexer top: refresh first, then the oldest eligible bank
// command, then power-down. Issues one command per cycle, combinationally.
// Assumes sources assert valid only for commands legal in this cycle.
module cmdmux_top
    import cmdmux_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int SEQ_W     = 8,
    localparam int N_SRC    = NUM_BANKS + 2,
    localparam int SRC_W    = $clog2(N_SRC),
    localparam int BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strict_mode,
    input  logic [N_SRC-1:0]        src_valid,
    input  logic [N_SRC*KIND_W-1:0] src_kind,
    input  logic [N_SRC*SEQ_W-1:0]  src_seq,
    output logic [N_SRC-1:0]        grant,
    output logic                    cmd_valid,
    output logic [KIND_W-1:0]       cmd_kind,
    output logic [SEQ_W-1:0]        cmd_seq,
    output logic [SRC_W-1:0]        cmd_src
);

    localparam int REF_IDX = NUM_BANKS;
    localparam int PD_IDX  = NUM_BANKS + 1;

    logic [NUM_BANKS-1:0] bank_elig;
    logic                 bank_found;
    logic [BIDX_W-1:0]    bank_idx;
    logic [SEQ_W-1:0]     expect_seq;
    logic                 from_bank;
    logic                 data_issued;

    cmdmux_order_track #(.SEQ_W(SEQ_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_issued (data_issued),
        .issued_seq  (cmd_seq),
        .expect_seq  (expect_seq)
    );

    cmdmux_bank_filter #(.NUM_BANKS(NUM_BANKS), .SEQ_W(SEQ_W)) u_filter (
        .strict_mode (strict_mode),
        .bank_valid  (src_valid[NUM_BANKS-1:0]),
        .bank_kind   (src_kind[NUM_BANKS*KIND_W-1:0]),
        .bank_seq    (src_seq[NUM_BANKS*SEQ_W-1:0]),
        .expect_seq  (expect_seq),
        .bank_elig   (bank_elig)
    );

    cmdmux_age_pick #(.NUM(NUM_BANKS), .SEQ_W(SEQ_W)) u_pick (
        .cand     (bank_elig),
        .cand_seq (src_seq[NUM_BANKS*SEQ_W-1:0]),
        .found    (bank_found),
        .pick_idx (bank_idx)
    );

    // Class arbitration: refresh, then bank, then power-down.
    always_comb begin
        cmd_valid = 1'b1;
        from_bank = 1'b0;
        cmd_src   = '0;
        if (src_valid[REF_IDX]) begin
            cmd_src = SRC_W'(REF_IDX);
        end else if (bank_found) begin
            cmd_src   = SRC_W'(bank_idx);
            from_bank = 1'b1;
        end else if (src_valid[PD_IDX]) begin
            cmd_src = SRC_W'(PD_IDX);
        end else begin
            cmd_valid = 1'b0;
        end
    end

    // Route the winner's fields and build the one-hot grant.
    always_comb begin
        grant    = '0;
        cmd_kind = KIND_NOP;
        cmd_seq  = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (cmd_valid && (cmd_src == SRC_W'(s))) begin
                grant[s] = 1'b1;
                cmd_kind = src_kind[s*KIND_W +: KIND_W];
                cmd_seq  = src_seq[s*SEQ_W +: SEQ_W];
            end
        end
    end

    // A bank read or write moves the expected order point.
    always_comb data_issued = from_bank && is_data_cmd(cmd_kind);

endmodule

// File: rtl/cmdmux_checker.sv
// Checker: temporal properties of the command multiplexer, bound to the top.
// Assumes reset is held for at least one clock at start.
module cmdmux_checker
    import cmdmux_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int SEQ_W     = 8,
    localparam int N_SRC    = NUM_BANKS + 2,
    localparam int SRC_W    = $clog2(N_SRC)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    strict_mode,
    input logic [N_SRC-1:0]        src_valid,
    input logic [N_SRC*KIND_W-1:0] src_kind,
    input logic [N_SRC*SEQ_W-1:0]  src_seq,
    input logic [N_SRC-1:0]        grant,
    input logic                    cmd_valid,
    input logic [KIND_W-1:0]       cmd_kind,
    input logic [SEQ_W-1:0]        cmd_seq,
    input logic [SRC_W-1:0]        cmd_src
);

    localparam int REF_IDX = NUM_BANKS;
    localparam int PD_IDX  = NUM_BANKS + 1;

    logic             bank_rw;
    logic             seen_rw;
    logic [SEQ_W-1:0] last_rw_seq;
    logic [SEQ_W-1:0] want_seq;

    // Observe whether the current issue is a bank read or write.
    always_comb begin
        bank_rw  = cmd_valid && (int'(cmd_src) < NUM_BANKS) && is_data_cmd(cmd_kind);
        want_seq = seen_rw ? last_rw_seq + SEQ_W'(1) : '0;
    end

    // Remember the last issued bank read or write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_rw     <= 1'b0;
            last_rw_seq <= '0;
        end else if (bank_rw) begin
            seen_rw     <= 1'b1;
            last_rw_seq <= cmd_seq;
        end
    end

    assert_idle_no_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid == '0) |-> (!cmd_valid && grant == '0));

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (cmd_valid == (grant != '0)));

    assert_grant_has_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> src_valid[cmd_src] && grant[cmd_src]);

    assert_refresh_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        src_valid[REF_IDX] |-> grant[REF_IDX]);

    assert_powerdown_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[PD_IDX] && !strict_mode) |-> (src_valid[REF_IDX:0] == '0));

    assert_strict_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (strict_mode && bank_rw) |-> (cmd_seq == want_seq));

endmodule

bind cmdmux_top cmdmux_checker #(
    .NUM_BANKS (NUM_BANKS),
    .SEQ_W     (SEQ_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strict_mode (strict_mode),
    .src_valid   (src_valid),
    .src_kind    (src_kind),
    .src_seq     (src_seq),
    .grant       (grant),
    .cmd_valid   (cmd_valid),
    .cmd_kind    (cmd_kind),
    .cmd_seq     (cmd_seq),
    .cmd_src     (cmd_src)
);

// File: tb/cmdmux_top_tb_top.sv
// Bench: vector table in oldest-first mode, then directed strict-order,
// reset and corner tests. Sources 0..3 are banks, 4 refresh, 5 power-down.
module cmdmux_top_tb_top;

    localparam int NB = 4;
    localparam int SW = 8;
    localparam int NS = NB + 2;
    localparam int NV = 11;

    localparam logic [2:0] K_ACT = 3'd0;
    localparam logic [2:0] K_PRE = 3'd1;
    localparam logic [2:0] K_RD  = 3'd2;
    localparam logic [2:0] K_WR  = 3'd3;
    localparam logic [2:0] K_REF = 3'd4;
    localparam logic [2:0] K_PDE = 3'd5;

    localparam logic [NS-1:0] T_VAL [NV] = '{
        6'b000000,  // R1 nothing valid
        6'b000001,  // R2 single bank
        6'b001111,  // R5 spread ages
        6'b000011,  // R5 wrap-around
        6'b001100,  // R6 tie
        6'b011111,  // R3 refresh over banks
        6'b100000,  // R4 power-down alone
        6'b101000,  // R4 bank over power-down
        6'b111111,  // R3 everything
        6'b110000,  // R3 refresh over power-down
        6'b000011   // R5 just under half range
    };
    localparam logic [NS*3-1:0] T_KIND [NV] = '{
        {K_PDE, K_REF, K_RD, K_RD, K_RD, K_RD},
        {K_PDE, K_REF, K_RD, K_RD, K_RD, K_RD},
        {K_PDE, K_REF, K_WR, K_ACT, K_RD, K_PRE},
        {K_PDE, K_REF, K_RD, K_RD, K_WR, K_RD},
        {K_PDE, K_REF, K_RD, K_WR, K_RD, K_RD},
        {K_PDE, K_REF, K_RD, K_RD, K_RD, K_RD},
        {K_PDE, K_REF, K_RD, K_RD, K_RD, K_RD},
        {K_PDE, K_REF, K_ACT, K_RD, K_RD, K_RD},
        {K_PDE, K_REF, K_RD, K_RD, K_RD, K_RD},
        {K_PDE, K_REF, K_RD, K_RD, K_RD, K_RD},
        {K_PDE, K_REF, K_RD, K_RD, K_PRE, K_RD}
    };
    localparam logic [NS*SW-1:0] T_SEQ [NV] = '{
        {8'd0, 8'd0, 8'd0,  8'd0, 8'd0,   8'd0},
        {8'd0, 8'd0, 8'd0,  8'd0, 8'd0,   8'd5},
        {8'd0, 8'd0, 8'd12, 8'd7, 8'd3,   8'd10},
        {8'd0, 8'd0, 8'd0,  8'd0, 8'd250, 8'd2},
        {8'd0, 8'd0, 8'd9,  8'd9, 8'd0,   8'd0},
        {8'd0, 8'd9, 8'd1,  8'd2, 8'd3,   8'd4},
        {8'd3, 8'd0, 8'd0,  8'd0, 8'd0,   8'd0},
        {8'd1, 8'd0, 8'd40, 8'd0, 8'd0,   8'd0},
        {8'd1, 8'd2, 8'd3,  8'd4, 8'd5,   8'd6},
        {8'd1, 8'd2, 8'd0,  8'd0, 8'd0,   8'd0},
        {8'd0, 8'd0, 8'd0,  8'd0, 8'd127, 8'd0}
    };
    localparam logic [NS-1:0] T_EXP [NV] = '{
        6'b000000, 6'b000001, 6'b000010, 6'b000010, 6'b000100, 6'b010000,
        6'b100000, 6'b001000, 6'b010000, 6'b010000, 6'b000001
    };
    localparam int T_REQ [NV] = '{1, 2, 5, 5, 6, 3, 4, 4, 3, 3, 5};

    logic             clk = 1'b0;
    logic             rst_n;
    logic             strict_mode;
    logic [NS-1:0]    src_valid;
    logic [NS*3-1:0]  src_kind;
    logic [NS*SW-1:0] src_seq;
    logic [NS-1:0]    grant;
    logic             cmd_valid;
    logic [2:0]       cmd_kind;
    logic [SW-1:0]    cmd_seq;
    logic [2:0]       cmd_src;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cmdmux_top #(.NUM_BANKS(NB), .SEQ_W(SW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .strict_mode (strict_mode),
        .src_valid   (src_valid),
        .src_kind    (src_kind),
        .src_seq     (src_seq),
        .grant       (grant),
        .cmd_valid   (cmd_valid),
        .cmd_kind    (cmd_kind),
        .cmd_seq     (cmd_seq),
        .cmd_src     (cmd_src)
    );

    // Compare grant and routed fields against the expected winner.
    task automatic check(input string req, input logic [NS-1:0] exp_g);
        logic          exp_v;
        logic [2:0]    exp_k;
        logic [SW-1:0] exp_s;
        logic [2:0]    exp_i;
        exp_v = (exp_g != '0);
        exp_k = 3'd7;
        exp_s = '0;
        exp_i = '0;
        for (int s = 0; s < NS; s++) begin
            if (exp_g[s]) begin
                exp_k = src_kind[s*3 +: 3];
                exp_s = src_seq[s*SW +: SW];
                exp_i = 3'(s);
            end
        end
        checks++;
        if (grant !== exp_g || cmd_valid !== exp_v ||
            (exp_v && (cmd_kind !== exp_k || cmd_seq !== exp_s || cmd_src !== exp_i))) begin
            fails++;
            $display("FAIL %s: grant=%b valid=%b kind=%0d seq=%0d src=%0d expected grant=%b valid=%b kind=%0d seq=%0d src=%0d",
                     req, grant, cmd_valid, cmd_kind, cmd_seq, cmd_src,
                     exp_g, exp_v, exp_k, exp_s, exp_i);
        end
    endtask

    // Drive one cycle's offer at the falling edge and let it settle.
    task automatic offer(input logic md, input logic [NS-1:0] v,
                         input logic [NS*3-1:0] k, input logic [NS*SW-1:0] s);
        @(negedge clk);
        strict_mode = md;
        src_valid   = v;
        src_kind    = k;
        src_seq     = s;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        src_valid = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        strict_mode = 1'b0;
        src_valid   = '0;
        src_kind    = '0;
        src_seq     = '0;
        do_reset();
        #1;
        check("R1 reset idle", 6'b000000);

        // Table walk, oldest-first mode.
        for (int v = 0; v < NV; v++) begin
            offer(1'b0, T_VAL[v], T_KIND[v], T_SEQ[v]);
            check($sformatf("R%0d vector %0d", T_REQ[v], v), T_EXP[v]);
        end

        // R10: after reset the expected number is 0.
        do_reset();
        // R7/R8: bank0 RD seq1 out of order is held; bank1 ACT seq5 goes.
        offer(1'b1, 6'b000011, {K_PDE, K_REF, K_RD, K_RD, K_ACT, K_RD},
              {8'd0, 8'd0, 8'd0, 8'd0, 8'd5, 8'd1});
        check("R8 activate bypasses strict hold", 6'b000010);
        // R10: bank1 WR seq0 matches the reset value and beats older-index RD seq1.
        offer(1'b1, 6'b000011, {K_PDE, K_REF, K_RD, K_RD, K_WR, K_RD},
              {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd1});
        check("R10 expected number starts at 0", 6'b000010);
        // R9: expected number is now 1.
        offer(1'b1, 6'b000001, {K_PDE, K_REF, K_RD, K_RD, K_RD, K_RD},
              {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd1});
        check("R9 advance to 1", 6'b000001);
        // R7: bank2 WR seq1 is older but stale; bank3 RD seq2 is in order.
        offer(1'b1, 6'b001100, {K_PDE, K_REF, K_RD, K_WR, K_RD, K_RD},
              {8'd0, 8'd0, 8'd2, 8'd1, 8'd0, 8'd0});
        check("R7 in-order read over older stale write", 6'b001000);
        // R4/R7: out-of-order read is held, so power-down goes.
        offer(1'b1, 6'b100001, {K_PDE, K_REF, K_RD, K_RD, K_RD, K_RD},
              {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd7});
        check("R4 power-down when reads held", 6'b100000);
        // R8: precharge with any number goes in strict mode.
        offer(1'b1, 6'b000100, {K_PDE, K_REF, K_RD, K_PRE, K_RD, K_RD},
              {8'd0, 8'd0, 8'd0, 8'd50, 8'd0, 8'd0});
        check("R8 precharge not held", 6'b000100);
        // R9: ACT/PRE/PD grants did not move the number (still 3).
        offer(1'b1, 6'b000011, {K_PDE, K_REF, K_RD, K_RD, K_RD, K_WR},
              {8'd0, 8'd0, 8'd0, 8'd0, 8'd3, 8'd4});
        check("R9 only data grants advance", 6'b000010);
        // R5: oldest-first mode ignores order; oldest stale write wins.
        offer(1'b0, 6'b001100, {K_PDE, K_REF, K_RD, K_WR, K_RD, K_RD},
              {8'd0, 8'd0, 8'd9, 8'd1, 8'd0, 8'd0});
        check("R5 oldest mode ignores order", 6'b000100);
        // R9: expected number is now 2 after the oldest-mode write.
        offer(1'b1, 6'b000011, {K_PDE, K_REF, K_RD, K_RD, K_RD, K_RD},
              {8'd0, 8'd0, 8'd0, 8'd0, 8'd2, 8'd3});
        check("R9 advance in oldest mode", 6'b000010);
        // R9: wrap of the expected number from 255 to 0.
        offer(1'b0, 6'b000001, {K_PDE, K_REF, K_RD, K_RD, K_RD, K_RD},
              {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd255});
        check("R9 grant seq 255", 6'b000001);
        offer(1'b1, 6'b000011, {K_PDE, K_REF, K_RD, K_RD, K_RD, K_RD},
              {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd1});
        check("R9 wrap to 0", 6'b000010);
        // R10: a mid-run reset returns the expected number to 0.
        offer(1'b1, 6'b000001, {K_PDE, K_REF, K_RD, K_RD, K_RD, K_RD},
              {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd1});
        check("R9 at 1 before reset", 6'b000001);
        do_reset();
        offer(1'b1, 6'b000011, {K_PDE, K_REF, K_RD, K_RD, K_RD, K_RD},
              {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd2});
        check("R10 reset clears expected number", 6'b000010);
        // R3: refresh beats an in-order read in strict mode.
        offer(1'b1, 6'b010001, {K_PDE, K_REF, K_RD, K_RD, K_RD, K_RD},
              {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd1});
        check("R3 refresh in strict mode", 6'b010000);
        // R1: idle again.
        offer(1'b1, 6'b000000, '0, '0);
        check("R1 idle", 6'b000000);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule